// File: doc/BRIEF.md
# Reciprocal Divisor Last-Digit Adjuster

This unit prepares a decimal divisor for a digit-serial reciprocal generator. The generator only handles divisors whose least significant decimal digit is 1, 8 or 9. The adjuster takes a BCD divisor and scales it until it ends in one of those digits. It multiplies the divisor by a small constant chosen from its last digit, or drops a trailing zero. Each multiplication is also applied to a numerator scale factor that starts at 1. Each dropped zero adds one to a decimal shift count.

When the run finishes, the original reciprocal can be rebuilt as 1/N = scale / adjusted x 10^-shift. The unit also reports three values for the generator: a rule code that selects its quotient-feedback function, the reduced divisor it works with, and the shift count it uses for final rescaling. A run starts with a one-cycle start strobe and ends with a one-cycle done pulse. The unit performs one adjustment step per clock. It stops early and raises a flag if a product does not fit its digit width, or if the step budget runs out.

Top module: `recip_lsd_adjust`

## Requirements
- R1: A start strobe is accepted only while idle. busy_o is high from the cycle after an accepted start until the run ends. done_o is a one-cycle pulse during which busy_o is low. A start strobe during a run has no effect on that run's results.
- R2: A working divisor ending in 0 loses that digit (decimal right shift), and the shift count rises by one. The scale factor is unchanged.
- R3: A working divisor ending in 2, 4 or 6 is multiplied by 5, and the scale factor is multiplied by 5.
- R4: A working divisor ending in 5 is multiplied by 2, and the scale factor is multiplied by 2.
- R5: A working divisor ending in 3 is multiplied by 3, so it ends in 9, and the scale factor is multiplied by 3.
- R6: A working divisor ending in 7 is multiplied by 7, so it ends in 9, and the scale factor is multiplied by 7.
- R7: The run stops successfully when the divisor ends in 9, 1 or 8, with mode code 2'b00, 2'b01 or 2'b10 respectively. gen_div_o is the divisor with its last digit removed, plus one for the 9 and 8 codes and unchanged for the 1 code.
- R8: After a successful run, scale x N equals adjusted x 10^shift.
- R9: If a multiply would exceed the divisor or scale digit width, the run stops with ovf_o set and mode 2'b11. gen_div_o is 0, and the other outputs keep the values from before the failing step.
- R10: After MAX_ITER steps without reaching 1, 8 or 9, the run stops with lim_o set and mode 2'b11. This includes the all-zero divisor. A divisor that reaches a final digit on the last allowed step still succeeds.
- R11: After reset, done_o and busy_o are 0, mode_o is 2'b11, and all numeric outputs are 0.
- R12: A run with A completed steps raises done_o exactly A+1 clocks after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| div_i | input | 4*NDIG | BCD divisor |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| adj_div_o | output | 4*(NDIG+1) | Adjusted BCD divisor |
| gen_div_o | output | 4*(NDIG+1) | Reduced BCD divisor for the generator |
| num_scale_o | output | 4*SDIG | BCD numerator scale factor |
| shift_o | output | clog2(MAX_ITER+1) | Decimal shift count |
| mode_o | output | 2 | Generator rule code (11 = none) |
| ovf_o | output | 1 | Width overflow stop |
| lim_o | output | 1 | Step-budget stop |

## Verification
The bench builds two copies. The first uses the defaults (3 input digits, 8 scale digits, 24 steps). It is swept over every divisor from 1 to 999, so every digit rule and every terminal digit is reached, and every result is compared with a bench model and with the scaling identity. The second copy uses 2 scale digits and an 8-step budget. This makes scale overflow reachable with small divisors such as 64. It also brings the step limit within reach, through the zero divisor and through a divisor that succeeds on exactly its last allowed step. The second copy is driven with seeded random divisors.

// File: rtl/recip_adj_pkg.sv
package recip_adj_pkg;

    typedef enum logic [1:0] {
        MODE_NINE  = 2'b00,
        MODE_ONE   = 2'b01,
        MODE_EIGHT = 2'b10,
        MODE_NONE  = 2'b11
    } gen_mode_e;

    typedef enum logic [1:0] {
        ACT_SHIFT = 2'b00,
        ACT_SCALE = 2'b01,
        ACT_STOP  = 2'b10,
        ACT_BAD   = 2'b11
    } adj_act_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } adj_state_e;

endpackage

// File: rtl/lsd_decode.sv
module lsd_decode
    import recip_adj_pkg::*;
(
    input  logic [3:0] lsd_i,
    output adj_act_e   act_o,
    output logic [3:0] mult_o,
    output gen_mode_e  mode_o
);

    always_comb begin
        act_o  = ACT_BAD;
        mult_o = 4'd1;
        mode_o = MODE_NONE;
        unique case (lsd_i)
            4'd0: act_o = ACT_SHIFT;
            4'd1: begin act_o = ACT_STOP;  mode_o = MODE_ONE;   end
            4'd2, 4'd4, 4'd6: begin act_o = ACT_SCALE; mult_o = 4'd5; end
            4'd3: begin act_o = ACT_SCALE; mult_o = 4'd3; end
            4'd5: begin act_o = ACT_SCALE; mult_o = 4'd2; end
            4'd7: begin act_o = ACT_SCALE; mult_o = 4'd7; end
            4'd8: begin act_o = ACT_STOP;  mode_o = MODE_EIGHT; end
            4'd9: begin act_o = ACT_STOP;  mode_o = MODE_NINE;  end
            default: act_o = ACT_BAD;
        endcase
    end

endmodule

// File: rtl/bcd_mul_const.sv
module bcd_mul_const #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] bcd_i,
    input  logic [3:0]          k_i,
    output logic [4*DIGITS-1:0] prod_o,
    output logic [3:0]          carry_o
);

    logic [3:0] cy [DIGITS+1];

    assign cy[0] = 4'd0;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [7:0] part;
        assign part = 8'(bcd_i[4*g +: 4]) * 8'(k_i) + 8'(cy[g]);
        assign prod_o[4*g +: 4] = 4'(part % 8'd10);
        assign cy[g+1] = 4'(part / 8'd10);
    end

    assign carry_o = cy[DIGITS];

endmodule

// File: rtl/bcd_incr.sv
module bcd_incr #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] bcd_i,
    input  logic                en_i,
    output logic [4*DIGITS-1:0] sum_o
);

    logic cy [DIGITS];

    assign cy[0] = en_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] dig;
        assign dig = bcd_i[4*g +: 4];
        assign sum_o[4*g +: 4] = !cy[g] ? dig : ((dig == 4'd9) ? 4'd0 : dig + 4'd1);
        if (g < DIGITS - 1) begin : g_ripple
            assign cy[g+1] = cy[g] && (dig == 4'd9);
        end
    end

endmodule

// File: rtl/recip_lsd_adjust.sv
module recip_lsd_adjust
    import recip_adj_pkg::*;
#(
    parameter int NDIG     = 3,
    parameter int SDIG     = 8,
    parameter int MAX_ITER = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    input  logic [4*NDIG-1:0]                div_i,
    output logic                             busy_o,
    output logic                             done_o,
    output logic [4*(NDIG+1)-1:0]            adj_div_o,
    output logic [4*(NDIG+1)-1:0]            gen_div_o,
    output logic [4*SDIG-1:0]                num_scale_o,
    output logic [$clog2(MAX_ITER+1)-1:0]    shift_o,
    output logic [1:0]                       mode_o,
    output logic                             ovf_o,
    output logic                             lim_o
);

    localparam int WDIG = NDIG + 1;
    localparam int DW   = 4 * WDIG;
    localparam int SW   = 4 * SDIG;
    localparam int PW   = $clog2(MAX_ITER + 1);

    typedef struct packed {
        adj_state_e      state;
        logic [DW-1:0]   dv;
        logic [SW-1:0]   sc;
        logic [PW-1:0]   sh;
        logic [PW-1:0]   it;
        gen_mode_e       mode;
        logic [DW-1:0]   gd;
        logic            done;
        logic            ovf;
        logic            lim;
    } adj_reg_t;

    localparam adj_reg_t RST_VAL = '{ST_IDLE, '0, '0, '0, '0, MODE_NONE, '0, 1'b0, 1'b0, 1'b0};

    adj_reg_t cs_q, ns_d;

    adj_act_e      act;
    logic [3:0]    mult;
    gen_mode_e     dec_mode;
    logic [DW-1:0] dv_prod, dv_drop, dv_inc;
    logic [SW-1:0] sc_prod;
    logic [3:0]    dv_cy, sc_cy;

    assign dv_drop = {4'h0, cs_q.dv[DW-1:4]};

    lsd_decode u_dec (
        .lsd_i  (cs_q.dv[3:0]),
        .act_o  (act),
        .mult_o (mult),
        .mode_o (dec_mode)
    );

    bcd_mul_const #(.DIGITS(WDIG)) u_dv_mul (
        .bcd_i   (cs_q.dv),
        .k_i     (mult),
        .prod_o  (dv_prod),
        .carry_o (dv_cy)
    );

    bcd_mul_const #(.DIGITS(SDIG)) u_sc_mul (
        .bcd_i   (cs_q.sc),
        .k_i     (mult),
        .prod_o  (sc_prod),
        .carry_o (sc_cy)
    );

    bcd_incr #(.DIGITS(WDIG)) u_inc (
        .bcd_i (dv_drop),
        .en_i  (dec_mode != MODE_ONE),
        .sum_o (dv_inc)
    );

    always_comb begin
        ns_d      = cs_q;
        ns_d.done = 1'b0;
        unique case (cs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ns_d.state = ST_RUN;
                    ns_d.dv    = {4'h0, div_i};
                    ns_d.sc    = SW'(1);
                    ns_d.sh    = '0;
                    ns_d.it    = '0;
                    ns_d.mode  = MODE_NONE;
                    ns_d.gd    = '0;
                    ns_d.ovf   = 1'b0;
                    ns_d.lim   = 1'b0;
                end
            end
            ST_RUN: begin
                if (act == ACT_STOP) begin
                    ns_d.state = ST_IDLE;
                    ns_d.done  = 1'b1;
                    ns_d.mode  = dec_mode;
                    ns_d.gd    = dv_inc;
                end else if (act == ACT_BAD) begin
                    ns_d.state = ST_IDLE;
                    ns_d.done  = 1'b1;
                    ns_d.ovf   = 1'b1;
                end else if (cs_q.it == PW'(MAX_ITER)) begin
                    ns_d.state = ST_IDLE;
                    ns_d.done  = 1'b1;
                    ns_d.lim   = 1'b1;
                end else if (act == ACT_SHIFT) begin
                    ns_d.dv = dv_drop;
                    ns_d.sh = cs_q.sh + PW'(1);
                    ns_d.it = cs_q.it + PW'(1);
                end else if ((dv_cy != 4'd0) || (sc_cy != 4'd0)) begin
                    ns_d.state = ST_IDLE;
                    ns_d.done  = 1'b1;
                    ns_d.ovf   = 1'b1;
                end else begin
                    ns_d.dv = dv_prod;
                    ns_d.sc = sc_prod;
                    ns_d.it = cs_q.it + PW'(1);
                end
            end
            default: ns_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= RST_VAL;
        end else begin
            cs_q <= ns_d;
        end
    end

    assign busy_o      = (cs_q.state == ST_RUN);
    assign done_o      = cs_q.done;
    assign adj_div_o   = cs_q.dv;
    assign gen_div_o   = cs_q.gd;
    assign num_scale_o = cs_q.sc;
    assign shift_o     = cs_q.sh;
    assign mode_o      = cs_q.mode;
    assign ovf_o       = cs_q.ovf;
    assign lim_o       = cs_q.lim;

endmodule

// File: rtl/recip_lsd_adjust_chk.sv
module recip_lsd_adjust_chk #(
    parameter int DW = 16,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [DW-1:0] adj_div_o,
    input logic [PW-1:0] shift_o,
    input logic [1:0]    mode_o,
    input logic          ovf_o,
    input logic          lim_o
);

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(adj_div_o) && $stable(mode_o) && $stable(shift_o)));

    // R2
    shift_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (shift_o >= $past(shift_o)));

    // R7
    mode_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_o == 2'b00) |-> (adj_div_o[3:0] == 4'd9));

    // R7
    mode_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_o == 2'b01) |-> (adj_div_o[3:0] == 4'd1));

    // R7
    mode_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_o == 2'b10) |-> (adj_div_o[3:0] == 4'd8));

    // R9
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (ovf_o || lim_o)) |-> (mode_o == 2'b11));

    // R10
    err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, lim_o}));

endmodule

bind recip_lsd_adjust recip_lsd_adjust_chk #(.DW(DW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .adj_div_o (adj_div_o),
    .shift_o   (shift_o),
    .mode_o    (mode_o),
    .ovf_o     (ovf_o),
    .lim_o     (lim_o)
);

// File: tb/recip_lsd_adjust_bench.sv
`timescale 1ns/1ps
module recip_lsd_adjust_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start_a = 1'b0, start_b = 1'b0;
    logic [11:0] div_a = '0, div_b = '0;
    logic        busy_a, done_a, ovf_a, lim_a, busy_b, done_b, ovf_b, lim_b;
    logic [15:0] adj_a, gen_a, adj_b, gen_b;
    logic [31:0] scl_a;
    logic [7:0]  scl_b;
    logic [4:0]  sh_a;
    logic [3:0]  sh_b;
    logic [1:0]  mode_a, mode_b;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    recip_lsd_adjust u_recip_lsd_adjust (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .div_i(div_a),
        .busy_o(busy_a), .done_o(done_a), .adj_div_o(adj_a), .gen_div_o(gen_a),
        .num_scale_o(scl_a), .shift_o(sh_a), .mode_o(mode_a), .ovf_o(ovf_a), .lim_o(lim_a)
    );

    recip_lsd_adjust #(.NDIG(3), .SDIG(2), .MAX_ITER(8)) u_recip_lsd_adjust_small (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .div_i(div_b),
        .busy_o(busy_b), .done_o(done_b), .adj_div_o(adj_b), .gen_div_o(gen_b),
        .num_scale_o(scl_b), .shift_o(sh_b), .mode_o(mode_b), .ovf_o(ovf_b), .lim_o(lim_b)
    );

    function automatic longint p10(input int e);
        longint r = 1;
        for (int i = 0; i < e; i++) r = r * 10;
        return r;
    endfunction

    function automatic logic [63:0] to_bcd(input longint v);
        logic [63:0] r = '0;
        longint t = v;
        for (int i = 0; i < 16; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic longint from_bcd(input logic [63:0] v);
        longint r = 0;
        for (int i = 15; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
        return r;
    endfunction

    task automatic ref_model(input longint n, input int sdig, input int wdig, input int maxit,
                             output longint m, output longint s, output int p, output int mode,
                             output longint g, output bit ovf, output bit lim, output int acts);
        longint nm, ns;
        int d, k;
        m = n; s = 1; p = 0; mode = 3; g = 0; ovf = 0; lim = 0; acts = 0;
        while (1) begin
            d = int'(m % 10);
            if (d == 1 || d == 8 || d == 9) begin
                mode = (d == 9) ? 0 : ((d == 1) ? 1 : 2);
                g = m / 10 + ((d != 1) ? 1 : 0);
                break;
            end
            if (acts == maxit) begin lim = 1; break; end
            if (d == 0) begin
                m = m / 10; p++;
            end else begin
                k = (d == 5) ? 2 : ((d == 3) ? 3 : ((d == 7) ? 7 : 5));
                nm = m * k; ns = s * k;
                if (nm >= p10(wdig) || ns >= p10(sdig)) begin ovf = 1; break; end
                m = nm; s = ns;
            end
            acts++;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input bit sel, input int n, input int intrude, input string tag);
        longint em, es, eg, am, as_, ag;
        int ep, emode, eacts, cyc, ap, amode;
        bit eovf, elim, aovf, alim, adone;
        ref_model(n, sel ? 2 : 8, 4, sel ? 8 : 24, em, es, ep, emode, eg, eovf, elim, eacts);
        @(negedge clk);
        if (sel) begin start_b = 1'b1; div_b = 12'(to_bcd(n)); end
        else     begin start_a = 1'b1; div_a = 12'(to_bcd(n)); end
        @(posedge clk);
        @(negedge clk);
        start_a = 1'b0; start_b = 1'b0;
        cyc = 0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            adone = sel ? done_b : done_a;
            if (adone || cyc > 300) break;
            if (cyc == intrude) begin
                start_a = 1'b1; div_a = 12'(to_bcd(7));
            end else begin
                start_a = 1'b0;
            end
        end
        start_a = 1'b0;
        am = from_bcd(64'(sel ? adj_b : adj_a));
        ag = from_bcd(64'(sel ? gen_b : gen_a));
        as_ = sel ? from_bcd(64'(scl_b)) : from_bcd(64'(scl_a));
        ap = sel ? int'(sh_b) : int'(sh_a);
        amode = sel ? int'(mode_b) : int'(mode_a);
        aovf = sel ? ovf_b : ovf_a;
        alim = sel ? lim_b : lim_a;
        // R12 latency
        chk(adone && cyc == eacts + 1, "R12", $sformatf("latency n=%0d", n), cyc, eacts + 1);
        chk(am == em, tag, $sformatf("adjusted n=%0d", n), am, em);
        chk(as_ == es, tag, $sformatf("scale n=%0d", n), as_, es);
        chk(ap == ep, tag, $sformatf("shift n=%0d", n), ap, ep);
        chk(amode == emode, tag, $sformatf("mode n=%0d", n), amode, emode);
        chk(ag == eg, tag, $sformatf("gen_div n=%0d", n), ag, eg);
        chk(aovf == eovf, tag, $sformatf("ovf n=%0d", n), aovf, eovf);
        chk(alim == elim, tag, $sformatf("lim n=%0d", n), alim, elim);
        if (!eovf && !elim) begin
            // R8 identity
            chk(as_ * n == am * p10(ap), "R8", $sformatf("identity n=%0d", n), as_ * n, am * p10(ap));
        end
        @(negedge clk);
        // R1 done is a single pulse
        adone = sel ? done_b : done_a;
        chk(!adone, "R1", $sformatf("done pulse n=%0d", n), adone, 0);
    endtask

    initial begin
        int r;
        void'($urandom(32'd51977));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!done_a && !busy_a, "R11", "done/busy after reset", {done_a, busy_a}, 0);
        chk(mode_a == 2'b11, "R11", "mode after reset", mode_a, 3);
        chk(adj_a == 0 && scl_a == 0 && sh_a == 0 && gen_a == 0, "R11", "numeric after reset", adj_a, 0);
        chk(mode_b == 2'b11 && !done_b, "R11", "small copy after reset", mode_b, 3);
        rst_n = 1'b1;
        @(negedge clk);

        run_case(0, 50, -1, "R2");
        run_case(0, 2, -1, "R3");
        run_case(0, 4, -1, "R3");
        run_case(0, 6, -1, "R3");
        run_case(0, 5, -1, "R4");
        run_case(0, 3, -1, "R5");
        run_case(0, 13, -1, "R5");
        run_case(0, 7, -1, "R6");
        run_case(0, 27, -1, "R6");
        run_case(0, 59, -1, "R7");
        run_case(0, 61, -1, "R7");
        run_case(0, 388, -1, "R7");
        run_case(0, 512, 1, "R1");
        run_case(1, 64, -1, "R9");
        run_case(1, 0, -1, "R10");
        run_case(1, 625, -1, "R10");
        run_case(0, 0, -1, "R10");

        for (int n = 1; n <= 999; n++) run_case(0, n, -1, "R8");

        for (int i = 0; i < 150; i++) begin
            r = int'($urandom_range(999, 0));
            run_case(1, r, -1, "R9");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule